// File: doc/BRIEF.md
# Variable-Length PWM Generator with Auto-Reload

This block produces several pulse-width-modulated outputs from one free-running 16-bit counter. Each channel runs in one of two modes. In variable-length mode the cycle is 8 to 15 bits long, and one global field sets that length. In wide mode the cycle uses the full 16-bit count. A channel output is low while the counted position inside the cycle is below the channel's live compare value, and high from that point on. A compare value of zero therefore keeps the output high for the whole cycle.

Each channel also has a shadow reload register. When a cycle ends, the block copies the shadow value into the live compare register, so software can change the duty cycle without a glitch. The live and shadow registers sit at the same two byte addresses, and a select bit in the control register decides which one the bus reaches. In 8-bit cycles the shadow register is not used. Instead, the high byte of the live register serves as the reload value for its low byte.

A cycle-overflow flag marks each end of a cycle at the selected length, and an enable bit can route that flag to the interrupt output. For wide-mode channels, a separate enable lets them reload when the whole counter overflows.

Top module: `pwm_autoreload`

## Requirements
- R1: The 3-bit length field `len` (control bits 2:0) sets the cycle length to 8+`len` bits. For a variable-length channel, `pwm_out` is 0 while (counter mod 2^(8+len)) < (live compare mod 2^(8+len)), and 1 otherwise.
- R2: A channel whose bit in the mode register (address 1, bit c for channel c) is 1 runs in wide mode. Its `pwm_out` is 0 while the full counter is below its 16-bit live compare and 1 otherwise, whatever the value of `len`.
- R3: Control bit 7 (`rsel`) steers every access to a channel's byte addresses 4+2c (low byte) and 5+2c (high byte). With `rsel`=0, reads and writes reach the live compare register. With `rsel`=1, they reach the shadow reload register.
- R4: For a variable-length channel with `len` from 1 to 7, the live compare takes the shadow value on the clock edge where the counter's low 8+`len` bits wrap from all ones to zero. At any other time it changes only through a bus write.
- R5: For a variable-length channel with `len`=0, on each 8-bit wrap the live compare low byte takes the value of the live compare high byte. The shadow register has no effect in this mode.
- R6: When control bit 3 (`ar16`) is 1, every wide-mode channel copies its shadow value into its live compare on the edge where the counter goes from FFFF to 0. When `ar16` is 0, no wide-mode reload takes place.
- R7: The overflow flag (control bit 5) sets on every wrap of the selected cycle length. Writing 1 to it sets it and writing 0 clears it. If a wrap and a clearing write fall on the same edge, the flag ends up set.
- R8: `irq` equals the overflow flag ANDed with control bit 6 (`ovf_ie`). It stays 0 while `ovf_ie` is 0.
- R9: After reset, the control register, the mode register, the counter and all compare registers are 0. Control bit 4 always reads 0, and writes to it are ignored.
- R10: The counter advances by one on every clock edge after reset. Address 2 reads its low byte and address 3 reads its high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Register byte address (AW = clog2(4+2*NUM_CH)) |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pwm_out | output | NUM_CH | One PWM output per channel |
| irq | output | 1 | Cycle-overflow interrupt |

## Verification
A live compare register that reloads on the wrong edge first shows up on the channel output, one cycle early or late at the wrap. Read back over the bus, it shows a stale or premature value in the cycle right after the wrap. A wrong mode or length decode changes the output's high/low boundary inside the very first cycle after setup. A flag that clears instead of setting on a collision is visible on the next read of the control register, and also on `irq` in the same cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CNT_W      = 16;
  localparam int BYTE_W     = 8;
  localparam int LEN_W      = 3;
  localparam int ADR_CTRL   = 0;
  localparam int ADR_MODE   = 1;
  localparam int ADR_CNT_LO = 2;
  localparam int ADR_CNT_HI = 3;
  localparam int CH_BASE    = 4;

  // ones in the low 8+sel bits
  function automatic logic [CNT_W-1:0] len_mask(input logic [LEN_W-1:0] sel);
    return {CNT_W{1'b1}} >> (4'd8 - {1'b0, sel});
  endfunction

  // last count of a cycle under the given mask
  function automatic logic at_wrap(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] mask);
    return (cnt & mask) == mask;
  endfunction

  // output level: high once the in-cycle position reaches the compare value
  function automatic logic duty_level(input logic [CNT_W-1:0] cnt,
                                      input logic [CNT_W-1:0] cmp,
                                      input logic [CNT_W-1:0] mask);
    return (cnt & mask) >= (cmp & mask);
  endfunction
endpackage

// File: rtl/pwm_cnt.sv
module pwm_cnt
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  len_sel,
  output logic [CNT_W-1:0]  cnt,
  output logic              len_wrap,
  output logic              full_wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign len_wrap  = at_wrap(cnt, len_mask(len_sel));
  assign full_wrap = &cnt;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic              wide,
  input  logic              ar16_en,
  input  logic              len_wrap,
  input  logic              full_wrap,
  input  logic [1:0]        wr_live,
  input  logic [1:0]        wr_rld,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  live,
  output logic [CNT_W-1:0]  rld,
  output logic              reload_evt,
  output logic              pwm
);
  logic [CNT_W-1:0] eff_mask;
  logic             byte_mode;

  assign byte_mode  = !wide && (len_sel == '0);
  assign eff_mask   = wide ? {CNT_W{1'b1}} : len_mask(len_sel);
  assign reload_evt = wide ? (ar16_en && full_wrap) : len_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      rld  <= '0;
    end else begin
      if (reload_evt) begin
        if (byte_mode) live[BYTE_W-1:0] <= live[CNT_W-1:BYTE_W];
        else           live <= rld;
      end
      // bus writes take precedence over a same-edge reload
      if (wr_live[0]) live[BYTE_W-1:0]     <= wdata;
      if (wr_live[1]) live[CNT_W-1:BYTE_W] <= wdata;
      if (wr_rld[0])  rld[BYTE_W-1:0]      <= wdata;
      if (wr_rld[1])  rld[CNT_W-1:BYTE_W]  <= wdata;
    end
  end

  assign pwm = duty_level(cnt, live, eff_mask);
endmodule

// File: rtl/pwm_autoreload.sv
module pwm_autoreload
  import pwm_pkg::*;
#(
  parameter  int NUM_CH = 2,
  localparam int AW     = $clog2(CH_BASE + 2*NUM_CH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out,
  output logic              irq
);
  logic             rsel_q, ovf_ie_q, ovf_flag_q, ar16_q;
  logic [LEN_W-1:0] len_q;
  logic [NUM_CH-1:0] mode16_q;
  logic             ctrl_wr, mode_wr;

  logic [CNT_W-1:0] cnt;
  logic             len_wrap, full_wrap;

  logic [NUM_CH-1:0][CNT_W-1:0] ch_live, ch_rld;
  logic [NUM_CH-1:0][1:0]       wr_live, wr_rld;
  logic [NUM_CH-1:0]            ch_reload, ch_live_wr;

  assign ctrl_wr = bus_we && (int'(bus_addr) == ADR_CTRL);
  assign mode_wr = bus_we && (int'(bus_addr) == ADR_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q   <= 1'b0;
      ovf_ie_q <= 1'b0;
      ar16_q   <= 1'b0;
      len_q    <= '0;
      mode16_q <= '0;
    end else begin
      if (ctrl_wr) begin
        rsel_q   <= bus_wdata[7];
        ovf_ie_q <= bus_wdata[6];
        ar16_q   <= bus_wdata[3];
        len_q    <= bus_wdata[LEN_W-1:0];
      end
      if (mode_wr) mode16_q <= bus_wdata[NUM_CH-1:0];
    end
  end

  // hardware set beats a software clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag_q <= 1'b0;
    else if (len_wrap) ovf_flag_q <= 1'b1;
    else if (ctrl_wr)  ovf_flag_q <= bus_wdata[5];
  end

  assign irq = ovf_flag_q & ovf_ie_q;

  pwm_cnt u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_sel   (len_q),
    .cnt       (cnt),
    .len_wrap  (len_wrap),
    .full_wrap (full_wrap)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int LO_ADR = CH_BASE + 2*c;
    assign wr_live[c][0] = bus_we && !rsel_q && (int'(bus_addr) == LO_ADR);
    assign wr_live[c][1] = bus_we && !rsel_q && (int'(bus_addr) == LO_ADR + 1);
    assign wr_rld[c][0]  = bus_we &&  rsel_q && (int'(bus_addr) == LO_ADR);
    assign wr_rld[c][1]  = bus_we &&  rsel_q && (int'(bus_addr) == LO_ADR + 1);
    assign ch_live_wr[c] = |wr_live[c];

    pwm_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt        (cnt),
      .len_sel    (len_q),
      .wide       (mode16_q[c]),
      .ar16_en    (ar16_q),
      .len_wrap   (len_wrap),
      .full_wrap  (full_wrap),
      .wr_live    (wr_live[c]),
      .wr_rld     (wr_rld[c]),
      .wdata      (bus_wdata),
      .live       (ch_live[c]),
      .rld        (ch_rld[c]),
      .reload_evt (ch_reload[c]),
      .pwm        (pwm_out[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) == ADR_CTRL)
      bus_rdata = {rsel_q, ovf_ie_q, ovf_flag_q, 1'b0, ar16_q, len_q};
    else if (int'(bus_addr) == ADR_MODE)
      bus_rdata[NUM_CH-1:0] = mode16_q;
    else if (int'(bus_addr) == ADR_CNT_LO)
      bus_rdata = cnt[BYTE_W-1:0];
    else if (int'(bus_addr) == ADR_CNT_HI)
      bus_rdata = cnt[CNT_W-1:BYTE_W];
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(bus_addr) == CH_BASE + 2*c)
        bus_rdata = rsel_q ? ch_rld[c][BYTE_W-1:0] : ch_live[c][BYTE_W-1:0];
      else if (int'(bus_addr) == CH_BASE + 2*c + 1)
        bus_rdata = rsel_q ? ch_rld[c][CNT_W-1:BYTE_W] : ch_live[c][CNT_W-1:BYTE_W];
    end
  end
endmodule

// File: rtl/pwm_autoreload_chk.sv
module pwm_autoreload_chk
  import pwm_pkg::*;
#(
  parameter  int NUM_CH = 2,
  localparam int AW     = $clog2(CH_BASE + 2*NUM_CH)
)(
  input logic                         clk,
  input logic                         rst_n,
  input logic [AW-1:0]                bus_addr,
  input logic [BYTE_W-1:0]            bus_rdata,
  input logic [CNT_W-1:0]             cnt,
  input logic                         len_wrap,
  input logic                         ovf_flag,
  input logic                         ovf_ie,
  input logic                         irq,
  input logic                         ar16,
  input logic [NUM_CH-1:0]            mode16,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_live,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_rld,
  input logic [NUM_CH-1:0]            ch_reload,
  input logic [NUM_CH-1:0]            ch_live_wr
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R10

  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    len_wrap |=> ovf_flag); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_ie |-> !irq); // R8

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) == ADR_CTRL) |-> !bus_rdata[4]); // R9

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_reload[c] && !ch_live_wr[c]) |=> $stable(ch_live[c])); // R4

    AST_WIDE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode16[c] && ch_reload[c] && !ch_live_wr[c]) |=> ch_live[c] == $past(ch_rld[c])); // R6

    AST_NO_RELOAD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (mode16[c] && !ar16) |-> !ch_reload[c]); // R6
  end
endmodule

bind pwm_autoreload pwm_autoreload_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .cnt        (cnt),
  .len_wrap   (len_wrap),
  .ovf_flag   (ovf_flag_q),
  .ovf_ie     (ovf_ie_q),
  .irq        (irq),
  .ar16       (ar16_q),
  .mode16     (mode16_q),
  .ch_live    (ch_live),
  .ch_rld     (ch_rld),
  .ch_reload  (ch_reload),
  .ch_live_wr (ch_live_wr)
);

// File: tb/pwm_autoreload_bench.sv
module pwm_autoreload_bench;
  localparam int NCH = 2;
  localparam int AWB = $clog2(4 + 2*NCH);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [AWB-1:0] bus_addr = '0;
  logic           bus_we = 1'b0;
  logic [7:0]     bus_wdata = '0;
  logic [7:0]     bus_rdata;
  logic [NCH-1:0] pwm_out;
  logic           irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] tb_cnt;

  always #5 clk = ~clk;

  // expected counter: zero in reset, one step per edge afterwards (R10)
  always @(posedge clk or negedge rst_n)
    if (!rst_n) tb_cnt <= 16'h0;
    else        tb_cnt <= tb_cnt + 16'h1;

  pwm_autoreload #(.NUM_CH(NCH)) u_pwm_autoreload (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [1:0]  wide;
    logic [15:0] c0;
    logic [15:0] c1;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'd0, 2'b00, 16'h0040, 16'h00C0},
    '{3'd1, 2'b00, 16'h0100, 16'h01F0},
    '{3'd2, 2'b00, 16'h0000, 16'h03FF},
    '{3'd0, 2'b01, 16'h8000, 16'h0080},
    '{3'd3, 2'b10, 16'h0200, 16'h0100},
    '{3'd7, 2'b00, 16'h4000, 16'h0010},
    '{3'd1, 2'b11, 16'h0300, 16'h0200},
    '{3'd0, 2'b00, 16'h0000, 16'h00FF}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next rising edge
  task automatic wr(input int a, input logic [7:0] d);
    bus_addr = AWB'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    bus_addr = AWB'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_low(input logic [15:0] mask, input logic [15:0] val);
    do @(negedge clk); while ((tb_cnt & mask) != val);
  endtask

  function automatic logic exp_lvl(input logic [15:0] cnt, input logic [15:0] cmp,
                                   input int sel, input bit wide);
    int unsigned period;
    period = wide ? 65536 : (256 << sel);
    return (int'(cnt) % period) >= (int'(cmp) % period);
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // ---- reset state (R9, R10, R1) ----
    rd(0, d); chk(d == 8'h00, "R9", "control after reset", d, 0);
    rd(1, d); chk(d == 8'h00, "R9", "mode after reset", d, 0);
    for (int a = 4; a < 8; a++) begin
      rd(a, d); chk(d == 8'h00, "R9", "compare after reset", d, 0);
    end
    chk(irq == 1'b0, "R8", "irq after reset", irq, 0);
    chk(pwm_out == 2'b11, "R1", "zero compare drives high", pwm_out, 3);
    rd(2, d); rd(3, d2);
    chk({d2, d} == tb_cnt, "R10", "counter read", {d2, d}, tb_cnt);

    // ---- table walk: output level over a window (R1, R2) ----
    for (int v = 0; v < 8; v++) begin
      int bad [NCH];
      logic [15:0] cv;
      wr(1, {6'b0, VEC[v].wide});
      wr(0, {5'b10000, VEC[v].sel});
      for (int c = 0; c < NCH; c++) begin
        cv = (c == 0) ? VEC[v].c0 : VEC[v].c1;
        wr(5 + 2*c, cv[15:8]);
        wr(4 + 2*c, cv[7:0]);
      end
      wr(0, {5'b00000, VEC[v].sel});
      for (int c = 0; c < NCH; c++) begin
        cv = (c == 0) ? VEC[v].c0 : VEC[v].c1;
        wr(5 + 2*c, (!VEC[v].wide[c] && VEC[v].sel == 3'd0) ? cv[7:0] : cv[15:8]);
        wr(4 + 2*c, cv[7:0]);
        bad[c] = 0;
      end
      repeat (2) @(negedge clk);
      for (int n = 0; n < 1100; n++) begin
        @(negedge clk); #1;
        for (int c = 0; c < NCH; c++) begin
          cv = (c == 0) ? VEC[v].c0 : VEC[v].c1;
          if (pwm_out[c] !== exp_lvl(tb_cnt, cv, int'(VEC[v].sel), VEC[v].wide[c])) bad[c]++;
        end
      end
      for (int c = 0; c < NCH; c++)
        chk(bad[c] == 0, VEC[v].wide[c] ? "R2" : "R1", "level mismatches in window", bad[c], 0);
    end
    rd(2, d); rd(3, d2);
    chk({d2, d} == tb_cnt, "R10", "counter read after table", {d2, d}, tb_cnt);

    // ---- select bit steers live/shadow (R3), ch1 wide, no reload ----
    wr(1, 8'h02);
    wr(0, 8'h00);
    wr(6, 8'h12); wr(7, 8'h56);
    wr(0, 8'h80);
    wr(6, 8'h34); wr(7, 8'h78);
    rd(0, d); chk(d == 8'h80, "R3", "select bit readback", d, 8'h80);
    rd(6, d); chk(d == 8'h34, "R3", "shadow low", d, 8'h34);
    rd(7, d); chk(d == 8'h78, "R3", "shadow high", d, 8'h78);
    wr(0, 8'h00);
    rd(6, d); chk(d == 8'h12, "R3", "live low", d, 8'h12);
    rd(7, d); chk(d == 8'h56, "R3", "live high", d, 8'h56);

    // ---- unused control bit (R9) ----
    wr(0, 8'h10);
    rd(0, d); chk(d[4] == 1'b0, "R9", "unused bit reads zero", d, 0);

    // ---- variable-length reload at wrap, 10-bit (R4) ----
    wait_low(16'h03FF, 16'd100);
    wr(0, 8'h82); wr(4, 8'h55); wr(5, 8'h01);
    wr(0, 8'h02); wr(4, 8'h22); wr(5, 8'h00);
    wait_low(16'h03FF, 16'h03FF);
    rd(4, d); chk(d == 8'h22, "R4", "live before wrap", d, 8'h22);
    @(negedge clk);
    rd(4, d); chk(d == 8'h55, "R4", "live low after wrap", d, 8'h55);
    rd(5, d); chk(d == 8'h01, "R4", "live high after wrap", d, 8'h01);

    // ---- 8-bit mode: high byte reloads low byte (R5) ----
    wr(0, 8'h00);
    wait_low(16'h00FF, 16'd40);
    wr(5, 8'hA0); wr(4, 8'h10);
    wait_low(16'h00FF, 16'h00FF);
    rd(4, d); chk(d == 8'h10, "R5", "low byte before wrap", d, 8'h10);
    @(negedge clk);
    rd(4, d); chk(d == 8'hA0, "R5", "low byte after wrap", d, 8'hA0);

    // ---- overflow flag and interrupt, 9-bit (R7, R8) ----
    wait_low(16'h01FF, 16'd200);
    wr(0, 8'h41);
    wait_low(16'h01FF, 16'h01FF);
    rd(0, d); chk(d[5] == 1'b0, "R7", "flag before wrap", d, 8'h41);
    chk(irq == 1'b0, "R8", "irq before wrap", irq, 0);
    @(negedge clk);
    rd(0, d); chk(d[5] == 1'b1, "R7", "flag after wrap", d, 8'h61);
    chk(irq == 1'b1, "R8", "irq with enable", irq, 1);
    wait_low(16'h01FF, 16'h01FF);
    wr(0, 8'h41);
    rd(0, d); chk(d[5] == 1'b1, "R7", "hw set beats clear", d, 8'h61);
    wait_low(16'h01FF, 16'd50);
    wr(0, 8'h21);
    rd(0, d); chk(d[5] == 1'b1, "R7", "software set", d, 8'h21);
    chk(irq == 1'b0, "R8", "irq masked", irq, 0);
    wr(0, 8'h41);
    rd(0, d); chk(d[5] == 1'b0, "R7", "software clear", d, 8'h41);
    chk(irq == 1'b0, "R8", "irq after clear", irq, 0);

    // ---- wide reload disabled then enabled (R6, R2) ----
    wr(1, 8'h01);
    wr(0, 8'h80); wr(4, 8'h34); wr(5, 8'h12);
    wr(0, 8'h00); wr(4, 8'h77); wr(5, 8'h07);
    wait_low(16'hFFFF, 16'hFFFF);
    @(negedge clk);
    rd(4, d); rd(5, d2);
    chk({d2, d} == 16'h0777, "R6", "no reload when disabled", {d2, d}, 16'h0777);
    wr(0, 8'h08);
    wait_low(16'hFFFF, 16'hFFFF);
    #1; chk(pwm_out[0] == 1'b1, "R2", "wide level at FFFF", pwm_out[0], 1);
    @(negedge clk);
    rd(4, d); rd(5, d2);
    chk({d2, d} == 16'h1234, "R6", "reload when enabled", {d2, d}, 16'h1234);
    chk(pwm_out[0] == 1'b0, "R2", "wide level after reload", pwm_out[0], 0);
    rd(2, d); rd(3, d2);
    chk({d2, d} == tb_cnt, "R10", "counter after wrap", {d2, d}, tb_cnt);

    summary();
    $finish;
  end
endmodule